// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This unit turns one IEEE-754 operand, single or double precision, into a signed two's-complement integer of either 32 or 64 bits. The caller chooses the rounding direction with an operation code. Four codes fix the direction: toward zero, toward minus infinity, toward plus infinity, and nearest with ties to even. A fifth code takes the direction from a separate 2-bit rounding-mode input. A conversion is requested by pulsing a valid input. The result, and the flags raised by that conversion, appear on registered outputs one clock later.

Each conversion can raise three exception flags: invalid, inexact and overflow. These flags are reported for the conversion that raised them. They are also ORed into a sticky status register, which only a reset clears. When a conversion is invalid, the integer result is replaced by a fixed sentinel. This applies to a NaN, an infinity, or a rounded value that reaches or passes either bound of the chosen integer width. Subnormal operands are converted by value and are not flushed to zero.

Top module: `fcvt_int_conv`

## Requirements
- R1: When `cvt_valid_i` is high, `done_o` is high on the next cycle and `result_o` holds the converted integer. Operation codes are 0 for toward zero, 1 for toward minus infinity, 2 for toward plus infinity, 3 for nearest-even and 4 for the direction given by `rmode_i`. Codes 5 to 7 act as code 0.
- R2: Code 1 returns the largest integer not above the operand. Code 2 returns the smallest integer not below it.
- R3: With nearest rounding, an operand exactly halfway between two integers gives the even one. Any other operand gives the closer integer.
- R4: Under code 4, `rmode_i` selects the direction: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R5: With `dbl_sel_i`=1 the whole 64-bit operand is a double. With `dbl_sel_i`=0 the low 32 bits are a single, and the upper 32 bits have no effect. Subnormals are converted by value.
- R6: A NaN raises only the invalid flag. An infinity raises both invalid and overflow.
- R7: The inexact flag is raised when a finite operand has a nonzero fraction. It stays clear when the operand is already an integer.
- R8: Overflow and invalid are raised together when the rounded value meets either bound of the target width. For 32 bits that means at or above 2^31-1, or at or below -2^31. For 64 bits it means at or above 2^63-1, or at or below -2^63.
- R9: An invalid conversion returns 0x7FFFFFFF for a 32-bit target (`wide_sel_i`=0) and 0x7FFFFFFFFFFFFFFF for a 64-bit target. A 32-bit result always has its upper 32 bits at zero.
- R10: Flag bits are laid out as bit 0 invalid, bit 1 inexact and bit 2 overflow. `flag_upd_o` shows the flags of the conversion on the cycle `done_o` is high, and is zero otherwise. `sticky_o` ORs in every update and never loses a bit until reset.
- R11: During and just after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cvt_valid_i | input | 1 | Conversion request |
| operand_i | input | 64 | Floating-point operand bits |
| dbl_sel_i | input | 1 | 1 = double, 0 = single in the low 32 bits |
| wide_sel_i | input | 1 | 1 = 64-bit target, 0 = 32-bit target |
| op_i | input | 3 | Rounding operation code |
| rmode_i | input | 2 | Rounding mode used by operation code 4 |
| done_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Converted integer or sentinel |
| flag_upd_o | output | 3 | Flags of this conversion (invalid, inexact, overflow) |
| sticky_o | output | 3 | Accumulated flags |

## Verification
One conversion can raise the range check and the inexact detection in the same cycle. Rounding 2147483646.6 to nearest with a 32-bit target is such a case. The fraction makes the result inexact, and rounding up lands exactly on 2^31-1. The bench expects all three flags and the sentinel together from that single request. A second case checks the sticky register while it folds a fresh update into bits it already holds. The bench reads the reported flags and the accumulated flags on the same cycle, and requires that earlier bits stay set.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

   typedef enum logic [2:0] {
      OP_TRUNC = 3'd0,
      OP_FLOOR = 3'd1,
      OP_CEIL  = 3'd2,
      OP_NEAR  = 3'd3,
      OP_DYN   = 3'd4
   } cvt_op_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } rmode_e;

   // internal rounding direction
   typedef enum logic [1:0] {
      DIR_ZERO,
      DIR_DOWN,
      DIR_UP,
      DIR_EVEN
   } dir_e;

   localparam int FLG_INV = 0;
   localparam int FLG_INX = 1;
   localparam int FLG_OVF = 2;
   localparam int FLG_W   = 3;

   function automatic dir_e pick_dir(input logic [2:0] op, input logic [1:0] rm);
      dir_e d;
      case (op)
         OP_FLOOR: d = DIR_DOWN;
         OP_CEIL:  d = DIR_UP;
         OP_NEAR:  d = DIR_EVEN;
         OP_DYN: begin
            case (rm)
               RM_NEAR: d = DIR_EVEN;
               RM_ZERO: d = DIR_ZERO;
               RM_UP:   d = DIR_UP;
               default: d = DIR_DOWN;
            endcase
         end
         default:  d = DIR_ZERO;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int MANT_W = 53,
   parameter int E_W    = 13
) (
   input  logic [EXP_W+FRAC_W:0]  bits_i,
   output logic                   sign_o,
   output logic signed [E_W-1:0]  exp_o,
   output logic [MANT_W-1:0]      mant_o,
   output logic                   nan_o,
   output logic                   inf_o
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int PAD  = MANT_W - 1 - FRAC_W;

   if (PAD < 0) begin : g_bad_mant
      $error("fcvt_unpack: MANT_W too small for FRAC_W");
   end
   if (E_W <= EXP_W) begin : g_bad_exp
      $error("fcvt_unpack: E_W must exceed EXP_W");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_zero;
   logic              exp_ones;
   logic signed [E_W-1:0] exp_ext;

   assign exp_f    = bits_i[EXP_W+FRAC_W-1:FRAC_W];
   assign frac_f   = bits_i[FRAC_W-1:0];
   assign exp_zero = ~|exp_f;
   assign exp_ones = &exp_f;
   assign exp_ext  = $signed(E_W'(exp_f));

   always_comb begin
      sign_o = bits_i[EXP_W+FRAC_W];
      nan_o  = exp_ones & (|frac_f);
      inf_o  = exp_ones & ~(|frac_f);
      // subnormals keep the minimum exponent and drop the hidden one
      exp_o  = exp_zero ? E_W'(1 - BIAS) : exp_ext - E_W'(BIAS);
      mant_o = MANT_W'({~exp_zero, frac_f}) << PAD;
   end

endmodule

// File: rtl/fcvt_align.sv
module fcvt_align #(
   parameter int WIDE_W = 64,
   parameter int MANT_W = 53,
   parameter int E_W    = 13
) (
   input  logic [MANT_W-1:0]      mant_i,
   input  logic signed [E_W-1:0]  exp_i,
   output logic [WIDE_W-1:0]      int_o,
   output logic                   guard_o,
   output logic                   sticky_o,
   output logic                   huge_o
);
   localparam int FX_W   = 2 * WIDE_W;
   localparam int BASE   = WIDE_W - (MANT_W - 1);
   localparam int E_MAX  = WIDE_W - 2;

   if (BASE < 1) begin : g_bad_width
      $error("fcvt_align: WIDE_W must exceed the mantissa width");
   end

   logic [FX_W-1:0] fx;
   logic            tiny;
   int              sh;

   always_comb begin
      huge_o = (exp_i > E_W'(E_MAX));
      tiny   = (exp_i < -E_W'(1));
      sh     = BASE + int'(exp_i);
      fx     = '0;
      if (!huge_o && !tiny) begin
         fx = FX_W'(mant_i) << sh;
      end
      int_o    = fx[FX_W-1:WIDE_W];
      guard_o  = fx[WIDE_W-1];
      sticky_o = (|fx[WIDE_W-2:0]) | (tiny & (|mant_i));
      if (huge_o) begin
         int_o = '1;
      end
   end

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
   import fcvt_pkg::*;
#(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic                 sign_i,
   input  logic [WIDE_W-1:0]    int_i,
   input  logic                 guard_i,
   input  logic                 sticky_i,
   input  logic                 huge_i,
   input  logic                 nan_i,
   input  logic                 inf_i,
   input  dir_e                 dir_i,
   input  logic                 wide_i,
   output logic [WIDE_W-1:0]    res_o,
   output logic [FLG_W-1:0]     flags_o
);
   localparam int MR_W = WIDE_W + 1;
   localparam logic [MR_W-1:0] POS_WIDE = (MR_W'(1) << (WIDE_W - 1)) - MR_W'(1);
   localparam logic [MR_W-1:0] NEG_WIDE = MR_W'(1) << (WIDE_W - 1);
   localparam logic [MR_W-1:0] POS_NARR = (MR_W'(1) << (NARROW_W - 1)) - MR_W'(1);
   localparam logic [MR_W-1:0] NEG_NARR = MR_W'(1) << (NARROW_W - 1);
   localparam logic [WIDE_W-1:0] SENT_WIDE = {1'b0, {(WIDE_W-1){1'b1}}};
   localparam logic [WIDE_W-1:0] SENT_NARR = WIDE_W'({1'b0, {(NARROW_W-1){1'b1}}});

   if (NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("fcvt_round: NARROW_W must be below WIDE_W");
   end

   logic              frac_nz;
   logic              bump;
   logic [MR_W-1:0]   mag_r;
   logic [MR_W-1:0]   lim;
   logic              range_bad;
   logic              ovf, inv, inx;
   logic [WIDE_W-1:0] sval;
   logic [WIDE_W-1:0] narrow_val;

   always_comb begin
      frac_nz = guard_i | sticky_i;
      case (dir_i)
         DIR_DOWN: bump = sign_i & frac_nz;
         DIR_UP:   bump = ~sign_i & frac_nz;
         DIR_EVEN: bump = guard_i & (sticky_i | int_i[0]);
         default:  bump = 1'b0;
      endcase
      mag_r = {1'b0, int_i} + MR_W'(bump);

      if (wide_i) lim = sign_i ? NEG_WIDE : POS_WIDE;
      else        lim = sign_i ? NEG_NARR : POS_NARR;
      range_bad = huge_i | (mag_r >= lim);

      ovf = ~nan_i & (inf_i | range_bad);
      inv = nan_i | ovf;
      inx = ~nan_i & ~inf_i & frac_nz;

      sval       = sign_i ? (~mag_r[WIDE_W-1:0] + WIDE_W'(1)) : mag_r[WIDE_W-1:0];
      narrow_val = WIDE_W'(sval[NARROW_W-1:0]);

      if (inv)         res_o = wide_i ? SENT_WIDE : SENT_NARR;
      else if (wide_i) res_o = sval;
      else             res_o = narrow_val;

      flags_o          = '0;
      flags_o[FLG_INV] = inv;
      flags_o[FLG_INX] = inx;
      flags_o[FLG_OVF] = ovf;
   end

endmodule

// File: rtl/fcvt_int_conv.sv
module fcvt_int_conv
   import fcvt_pkg::*;
#(
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter int WIDE_W     = 64,
   parameter int NARROW_W   = 32,
   parameter bit SINGLE_EN  = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cvt_valid_i,
   input  logic [DBL_EXP_W+DBL_FRAC_W:0]      operand_i,
   input  logic                               dbl_sel_i,
   input  logic                               wide_sel_i,
   input  logic [2:0]                         op_i,
   input  logic [1:0]                         rmode_i,
   output logic                               done_o,
   output logic [WIDE_W-1:0]                  result_o,
   output logic [FLG_W-1:0]                   flag_upd_o,
   output logic [FLG_W-1:0]                   sticky_o
);
   localparam int MANT_W = DBL_FRAC_W + 1;
   localparam int E_W    = DBL_EXP_W + 2;
   localparam int SGL_W  = 1 + SGL_EXP_W + SGL_FRAC_W;

   if (SGL_EXP_W >= DBL_EXP_W || SGL_FRAC_W >= DBL_FRAC_W) begin : g_bad_fmt
      $error("fcvt_int_conv: single format must be narrower than double");
   end

   logic                  d_sign, d_nan, d_inf;
   logic signed [E_W-1:0] d_exp;
   logic [MANT_W-1:0]     d_mant;

   fcvt_unpack #(
      .EXP_W (DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .MANT_W(MANT_W), .E_W(E_W)
   ) u_unpk_dbl (
      .bits_i(operand_i), .sign_o(d_sign), .exp_o(d_exp), .mant_o(d_mant),
      .nan_o(d_nan), .inf_o(d_inf)
   );

   logic                  sel_sign, sel_nan, sel_inf;
   logic signed [E_W-1:0] sel_exp;
   logic [MANT_W-1:0]     sel_mant;

   if (SINGLE_EN) begin : g_sgl
      logic                  s_sign, s_nan, s_inf;
      logic signed [E_W-1:0] s_exp;
      logic [MANT_W-1:0]     s_mant;

      fcvt_unpack #(
         .EXP_W (SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .MANT_W(MANT_W), .E_W(E_W)
      ) u_unpk_sgl (
         .bits_i(operand_i[SGL_W-1:0]), .sign_o(s_sign), .exp_o(s_exp),
         .mant_o(s_mant), .nan_o(s_nan), .inf_o(s_inf)
      );

      always_comb begin
         sel_sign = dbl_sel_i ? d_sign : s_sign;
         sel_exp  = dbl_sel_i ? d_exp  : s_exp;
         sel_mant = dbl_sel_i ? d_mant : s_mant;
         sel_nan  = dbl_sel_i ? d_nan  : s_nan;
         sel_inf  = dbl_sel_i ? d_inf  : s_inf;
      end
   end else begin : g_dbl_only
      always_comb begin
         sel_sign = d_sign;
         sel_exp  = d_exp;
         sel_mant = d_mant;
         sel_nan  = d_nan;
         sel_inf  = d_inf;
      end
   end

   logic [WIDE_W-1:0] int_mag;
   logic              grd, stk, huge;

   fcvt_align #(.WIDE_W(WIDE_W), .MANT_W(MANT_W), .E_W(E_W)) u_align (
      .mant_i(sel_mant), .exp_i(sel_exp), .int_o(int_mag),
      .guard_o(grd), .sticky_o(stk), .huge_o(huge)
   );

   dir_e              dir;
   logic [WIDE_W-1:0] res_c;
   logic [FLG_W-1:0]  flg_c;

   assign dir = pick_dir(op_i, rmode_i);

   fcvt_round #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_round (
      .sign_i(sel_sign), .int_i(int_mag), .guard_i(grd), .sticky_i(stk),
      .huge_i(huge), .nan_i(sel_nan), .inf_i(sel_inf), .dir_i(dir),
      .wide_i(wide_sel_i), .res_o(res_c), .flags_o(flg_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         result_o   <= '0;
         flag_upd_o <= '0;
         sticky_o   <= '0;
      end else begin
         done_o     <= cvt_valid_i;
         flag_upd_o <= cvt_valid_i ? flg_c : '0;
         if (cvt_valid_i) begin
            result_o <= res_c;
            sticky_o <= sticky_o | flg_c;
         end
      end
   end

   // R1
   done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cvt_valid_i |=> done_o);

   // R8
   ovf_implies_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && flag_upd_o[FLG_OVF]) |-> flag_upd_o[FLG_INV]);

   // R9
   inv_gives_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && flag_upd_o[FLG_INV]) |->
      (result_o == WIDE_W'({1'b0, {(NARROW_W-1){1'b1}}}) ||
       result_o == {1'b0, {(WIDE_W-1){1'b1}}}));

   // R10
   upd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (flag_upd_o == '0));

   // R10
   sticky_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

   // R10
   sticky_holds_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((sticky_o & flag_upd_o) == flag_upd_o));

endmodule

// File: tb/fcvt_int_conv_test.sv
module fcvt_int_conv_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cvt_valid_i = 1'b0;
   logic [63:0] operand_i = '0;
   logic        dbl_sel_i = 1'b1;
   logic        wide_sel_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  rmode_i = '0;
   logic        done_o;
   logic [63:0] result_o;
   logic [2:0]  flag_upd_o;
   logic [2:0]  sticky_o;

   int vec_n = 0;
   int bad_n = 0;
   bit finished = 1'b0;

   localparam logic [2:0] F_NONE = 3'b000;
   localparam logic [2:0] F_INV  = 3'b001;
   localparam logic [2:0] F_INX  = 3'b010;
   localparam logic [2:0] F_OVF  = 3'b100;
   localparam logic [63:0] S32 = 64'h0000_0000_7FFF_FFFF;
   localparam logic [63:0] S64 = 64'h7FFF_FFFF_FFFF_FFFF;

   always #5 clk = ~clk;

   fcvt_int_conv uut (
      .clk(clk), .rst_n(rst_n), .cvt_valid_i(cvt_valid_i), .operand_i(operand_i),
      .dbl_sel_i(dbl_sel_i), .wide_sel_i(wide_sel_i), .op_i(op_i), .rmode_i(rmode_i),
      .done_o(done_o), .result_o(result_o), .flag_upd_o(flag_upd_o), .sticky_o(sticky_o)
   );

   function automatic logic [63:0] dbl(input real r);
      return $realtobits(r);
   endfunction

   // single-precision bits for values exactly representable as normal singles
   function automatic logic [31:0] sgl(input real r);
      logic [63:0] b;
      logic [10:0] e;
      b = $realtobits(r);
      e = b[62:52] - 11'd896;
      return {b[63], e[7:0], b[51:29]};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vec_n++;
      if (act !== exp) begin
         bad_n++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic convert(input logic [63:0] opnd, input logic dbl_s, input logic wide_s,
                          input logic [2:0] op, input logic [1:0] rm);
      @(negedge clk);
      operand_i   = opnd;
      dbl_sel_i   = dbl_s;
      wide_sel_i  = wide_s;
      op_i        = op;
      rmode_i     = rm;
      cvt_valid_i = 1'b1;
      @(negedge clk);
      cvt_valid_i = 1'b0;
   endtask

   task automatic expect_cvt(input string tag, input logic [63:0] er, input logic [2:0] ef);
      check({tag, " done"}, 64'(done_o), 64'd1);
      check({tag, " result"}, result_o, er);
      check({tag, " flags"}, 64'(flag_upd_o), 64'(ef));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 reset done", 64'(done_o), 64'd0);
      check("R11 reset result", result_o, 64'd0);
      check("R11 reset flags", {58'd0, flag_upd_o, sticky_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after reset", {58'd0, flag_upd_o, sticky_o}, 64'd0);
   endtask

   task automatic t_trunc;
      convert(dbl(2.7), 1, 0, 3'd0, 2'd0);
      expect_cvt("R1 trunc 2.7", 64'd2, F_INX);
      convert(dbl(-2.7), 1, 0, 3'd0, 2'd0);
      expect_cvt("R1 trunc -2.7", 64'h0000_0000_FFFF_FFFE, F_INX);
      convert(dbl(-2.7), 1, 0, 3'd6, 2'd2);
      expect_cvt("R1 code6 as trunc", 64'h0000_0000_FFFF_FFFE, F_INX);
   endtask

   task automatic t_floor_ceil;
      convert(dbl(-2.5), 1, 0, 3'd1, 2'd0);
      expect_cvt("R2 floor -2.5", 64'h0000_0000_FFFF_FFFD, F_INX);
      convert(dbl(2.1), 1, 0, 3'd2, 2'd0);
      expect_cvt("R2 ceil 2.1", 64'd3, F_INX);
      convert(dbl(3.0), 1, 0, 3'd1, 2'd0);
      expect_cvt("R7 floor exact 3.0", 64'd3, F_NONE);
      convert(64'h0000_0000_0000_0001, 1, 0, 3'd2, 2'd0);
      expect_cvt("R5 ceil subnormal", 64'd1, F_INX);
      convert(64'h0000_0000_0000_0001, 1, 0, 3'd1, 2'd0);
      expect_cvt("R5 floor subnormal", 64'd0, F_INX);
   endtask

   task automatic t_nearest;
      convert(dbl(2.5), 1, 0, 3'd3, 2'd0);
      expect_cvt("R3 near 2.5", 64'd2, F_INX);
      convert(dbl(3.5), 1, 0, 3'd3, 2'd0);
      expect_cvt("R3 near 3.5", 64'd4, F_INX);
      convert(dbl(-2.5), 1, 0, 3'd3, 2'd0);
      expect_cvt("R3 near -2.5", 64'h0000_0000_FFFF_FFFE, F_INX);
      convert(dbl(2.6), 1, 0, 3'd3, 2'd0);
      expect_cvt("R3 near 2.6", 64'd3, F_INX);
   endtask

   task automatic t_mode_field;
      convert(dbl(-1.9), 1, 0, 3'd4, 2'd1);
      expect_cvt("R4 mode zero -1.9", 64'h0000_0000_FFFF_FFFF, F_INX);
      convert(dbl(1.1), 1, 0, 3'd4, 2'd2);
      expect_cvt("R4 mode up 1.1", 64'd2, F_INX);
      convert(dbl(1.1), 1, 0, 3'd4, 2'd3);
      expect_cvt("R4 mode down 1.1", 64'd1, F_INX);
      convert(dbl(0.5), 1, 0, 3'd4, 2'd0);
      expect_cvt("R4 mode near 0.5", 64'd0, F_INX);
   endtask

   task automatic t_single_wide;
      convert({32'hDEAD_BEEF, sgl(1.5)}, 0, 0, 3'd0, 2'd0);
      expect_cvt("R5 single 1.5", 64'd1, F_INX);
      convert({32'h1234_5678, sgl(3.5)}, 0, 0, 3'd3, 2'd0);
      expect_cvt("R5 single near 3.5", 64'd4, F_INX);
      convert(dbl(1099511627776.5), 1, 1, 3'd3, 2'd0);
      expect_cvt("R9 wide near 2^40+.5", 64'h0000_0100_0000_0000, F_INX);
      convert(dbl(-3.0), 1, 1, 3'd0, 2'd0);
      expect_cvt("R9 wide -3", 64'hFFFF_FFFF_FFFF_FFFD, F_NONE);
   endtask

   task automatic t_special;
      convert(64'h7FF8_0000_0000_0000, 1, 0, 3'd0, 2'd0);
      expect_cvt("R6 NaN", S32, F_INV);
      convert(64'h7FF0_0000_0000_0000, 1, 0, 3'd2, 2'd0);
      expect_cvt("R6 +inf", S32, F_INV | F_OVF);
      convert({32'h0, 32'h7FC0_0000}, 0, 1, 3'd1, 2'd0);
      expect_cvt("R6 single NaN wide", S64, F_INV);
   endtask

   task automatic t_range;
      convert(dbl(2147483647.0), 1, 0, 3'd0, 2'd0);
      expect_cvt("R8 at max32", S32, F_INV | F_OVF);
      convert(dbl(2147483646.0), 1, 0, 3'd0, 2'd0);
      expect_cvt("R8 below max32", 64'h0000_0000_7FFF_FFFE, F_NONE);
      convert(dbl(-2147483648.0), 1, 0, 3'd0, 2'd0);
      expect_cvt("R8 at min32", S32, F_INV | F_OVF);
      convert(dbl(-2147483647.0), 1, 0, 3'd0, 2'd0);
      expect_cvt("R8 above min32", 64'h0000_0000_8000_0001, F_NONE);
      // inexact, range and invalid raised by one conversion
      convert(dbl(2147483646.6), 1, 0, 3'd3, 2'd0);
      expect_cvt("R8 round onto max32", S32, F_INV | F_INX | F_OVF);
      convert(dbl(9223372036854775808.0), 1, 1, 3'd0, 2'd0);
      expect_cvt("R8 2^63 wide", S64, F_INV | F_OVF);
      convert(dbl(4611686018427387904.0), 1, 1, 3'd0, 2'd0);
      expect_cvt("R8 2^62 wide", 64'h4000_0000_0000_0000, F_NONE);
   endtask

   task automatic t_sticky;
      t_reset();
      convert(dbl(5.0), 1, 0, 3'd0, 2'd0);
      check("R10 sticky after exact", 64'(sticky_o), 64'(F_NONE));
      convert(dbl(5.5), 1, 0, 3'd0, 2'd0);
      check("R10 sticky inexact", 64'(sticky_o), 64'(F_INX));
      @(negedge clk);
      check("R10 upd idle zero", 64'(flag_upd_o), 64'd0);
      convert(dbl(7.0), 1, 0, 3'd0, 2'd0);
      check("R10 sticky kept", 64'(sticky_o), 64'(F_INX));
      convert(64'h7FF8_0000_0000_0000, 1, 0, 3'd0, 2'd0);
      check("R10 upd NaN", 64'(flag_upd_o), 64'(F_INV));
      check("R10 sticky merged", 64'(sticky_o), 64'(F_INV | F_INX));
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      vec_n++;
      bad_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_trunc();
      t_floor_ceil();
      t_nearest();
      t_mode_field();
      t_single_wide();
      t_special();
      t_range();
      t_sticky();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule